// File: doc/BRIEF.md
# Segment Register with Descriptor Cache

This block is one segment register of a protected-mode address unit. It holds a 16-bit selector and, hidden behind it, a cached copy of the 8-byte descriptor that the selector names. Writing a selector starts a load. The block splits the selector into a requestor privilege level, a table-select bit and a 13-bit entry index. It then forms the entry address from the global or the local table base and reads the descriptor as two 32-bit words over a simple request/acknowledge memory port. If the in-memory copy has not yet been marked as used, the block writes the upper word back with that mark set.

Once the load ends, the protection and address logic reads the cached base, limit, access byte and flags from dedicated outputs. The table in memory is never read again until the selector is rewritten. An edit to a descriptor in memory therefore reaches these outputs only after a reload. Software-visible read-back returns the selector alone.

Top module: `segDescCache`

## Requirements
- R1: While and after reset, with no selector write, busy, done, memReq and memWe are 0, selRdData is 0 and descPresent is 0.
- R2: A selector write (selWrEn high at a clock edge while busy is 0) makes selRdData equal the written value and raises busy from the next cycle on. busy rises only after such a write.
- R3: The first memory read of a load uses address tableBase + 8 × selector[15:3]. tableBase is ldtBase when selector bit 2 is 1 and gdtBase when it is 0. The rpl output equals selector[1:0].
- R4: A load issues a read of the entry's low word, then a read of the entry address + 4. Each request holds memReq and memAddr steady until the cycle in which memAck is high.
- R5: When a load finishes, the outputs take these values, with lo and hi being the two words read. descBase = {hi[31:24], hi[7:0], lo[31:16]}. descLimit = {hi[19:16], lo[15:0]}. descAccess = hi[15:8] with bit 0 forced to 1. descFlags = hi[23:20]. descPresent = descAccess[7]. descDpl = descAccess[6:5].
- R6: If bit 8 of the high word read is 0, one write follows the two reads, to entry address + 4 with data hi | 0x100. If that bit is 1, no write is issued.
- R7: done is a one-cycle pulse in the cycle after the acknowledge of the last memory operation of a load. The new cached values are already on the outputs in that cycle, and busy is 0 in it.
- R8: Outside a load, no memory request is made. The cached outputs keep their values even when the table in memory changes, until the next selector write.
- R9: A selector write while busy is 1 is ignored: selRdData keeps its value and no additional memory operation is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selWrEn | input | 1 | Selector write strobe |
| selWrData | input | 16 | Selector value to write |
| selRdData | output | 16 | Current selector value |
| gdtBase | input | ADDR_W | Global table base address |
| ldtBase | input | ADDR_W | Local table base address |
| memReq | output | 1 | Memory operation request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Byte address of the operation |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Operation completes this cycle |
| busy | output | 1 | Descriptor load in progress |
| done | output | 1 | One-cycle load-complete pulse |
| descBase | output | 32 | Cached segment base |
| descLimit | output | 20 | Cached segment limit |
| descAccess | output | 8 | Cached access byte |
| descFlags | output | 4 | Cached flag nibble |
| descPresent | output | 1 | Cached present bit |
| descDpl | output | 2 | Cached descriptor privilege level |
| rpl | output | 2 | Requestor privilege level of the selector |

## Verification
The selector read-back and busy are due one cycle after the write edge. Each memory operation completes in the cycle its acknowledge is seen. done follows one cycle after the last acknowledge, so a load of N operations with a memory latency of L cycles ends N × (1 + L) + 1 cycles after the write. The bench drives latencies of 0, 1 and 2 and checks done at exactly that cycle count. A scoreboard queue holds the operations expected from each selector and is compared as each acknowledge is given, so a missing, extra or misaddressed operation is caught in the cycle it happens. Outputs are sampled on the falling edge, half a cycle after the registers settle.

// File: rtl/segDescPkg.sv
package segDescPkg;
  localparam int SEL_W = 16;
  localparam int WORD_W = 32;
  localparam int IDX_LSB = 3;
  localparam int TI_BIT = 2;
  localparam int ACC_BIT = 8;   // accessed flag inside the upper descriptor word

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDLO, ST_RDHI, ST_WRACC, ST_DONE
  } segState_t;

  typedef struct packed {
    logic selLoad;   // latch new selector
    logic capLo;     // capture low descriptor word
    logic capHi;     // capture high descriptor word
    logic commit;    // copy staged descriptor into the cache
    logic hiAddr;    // address the upper word (+4)
  } segStrobe_t;
endpackage

// File: rtl/segDescCtrl.sv
module segDescCtrl
  import segDescPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selWrEn,
  input  logic       memAck,
  input  logic       accBit,
  output segStrobe_t strobe,
  output logic       memReq,
  output logic       memWe,
  output logic       busy,
  output logic       done
);
  segState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe = '0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        nextState = ST_IDLE;
        if (selWrEn) begin
          strobe.selLoad = 1'b1;
          nextState = ST_RDLO;
        end
      end
      ST_RDLO: begin
        if (memAck) begin
          strobe.capLo = 1'b1;
          nextState = ST_RDHI;
        end
      end
      ST_RDHI: begin
        strobe.hiAddr = 1'b1;
        if (memAck) begin
          strobe.capHi = 1'b1;
          if (accBit) begin
            strobe.commit = 1'b1;
            nextState = ST_DONE;
          end else begin
            nextState = ST_WRACC;
          end
        end
      end
      ST_WRACC: begin
        strobe.hiAddr = 1'b1;
        if (memAck) begin
          strobe.commit = 1'b1;
          nextState = ST_DONE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign memReq = (state == ST_RDLO) || (state == ST_RDHI) || (state == ST_WRACC);
  assign memWe  = (state == ST_WRACC);
  assign busy   = memReq;
  assign done   = (state == ST_DONE);
endmodule

// File: rtl/segDescDatapath.sv
module segDescDatapath
  import segDescPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  segStrobe_t        strobe,
  input  logic [SEL_W-1:0]  selWrData,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [ADDR_W-1:0] ldtBase,
  input  logic [WORD_W-1:0] memRdata,
  output logic [SEL_W-1:0]  selQ,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [31:0]       descBase,
  output logic [19:0]       descLimit,
  output logic [7:0]        descAccess,
  output logic [3:0]        descFlags
);
  localparam int OFS_W = SEL_W;
  logic [WORD_W-1:0] loWord, hiWord, hiSrc;
  logic [ADDR_W-1:0] tableBase, entryAddr;
  logic [OFS_W-1:0]  entryOfs;

  assign tableBase = selQ[TI_BIT] ? ldtBase : gdtBase;
  assign entryOfs  = {selQ[SEL_W-1:IDX_LSB], 3'b000};
  assign entryAddr = tableBase + ADDR_W'(entryOfs);
  assign memAddr   = strobe.hiAddr ? entryAddr + ADDR_W'(4) : entryAddr;
  assign memWdata  = hiWord | (WORD_W'(1) << ACC_BIT);
  assign hiSrc     = strobe.capHi ? memRdata : hiWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
      loWord <= '0;
      hiWord <= '0;
      descBase <= '0;
      descLimit <= '0;
      descAccess <= '0;
      descFlags <= '0;
    end else begin
      if (strobe.selLoad) selQ <= selWrData;
      if (strobe.capLo) loWord <= memRdata;
      if (strobe.capHi) hiWord <= memRdata;
      if (strobe.commit) begin
        descBase   <= {hiSrc[31:24], hiSrc[7:0], loWord[31:16]};
        descLimit  <= {hiSrc[19:16], loWord[15:0]};
        descAccess <= {hiSrc[15:9], 1'b1};
        descFlags  <= hiSrc[23:20];
      end
    end
  end
endmodule

// File: rtl/segDescCache.sv
module segDescCache
  import segDescPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selWrEn,
  input  logic [15:0]       selWrData,
  output logic [15:0]       selRdData,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [ADDR_W-1:0] ldtBase,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic              busy,
  output logic              done,
  output logic [31:0]       descBase,
  output logic [19:0]       descLimit,
  output logic [7:0]        descAccess,
  output logic [3:0]        descFlags,
  output logic              descPresent,
  output logic [1:0]        descDpl,
  output logic [1:0]        rpl
);
  segStrobe_t strobe;

  segDescCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .selWrEn(selWrEn), .memAck(memAck),
    .accBit(memRdata[ACC_BIT]), .strobe(strobe), .memReq(memReq),
    .memWe(memWe), .busy(busy), .done(done)
  );

  segDescDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selWrData(selWrData),
    .gdtBase(gdtBase), .ldtBase(ldtBase), .memRdata(memRdata),
    .selQ(selRdData), .memAddr(memAddr), .memWdata(memWdata),
    .descBase(descBase), .descLimit(descLimit), .descAccess(descAccess),
    .descFlags(descFlags)
  );

  assign descPresent = descAccess[7];
  assign descDpl     = descAccess[6:5];
  assign rpl         = selRdData[1:0];
endmodule

// File: rtl/segDescCache_chk.sv
module segDescCache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              selWrEn,
  input logic [15:0]       selRdData,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic              memAck,
  input logic              busy,
  input logic              done,
  input logic [7:0]        descAccess
);
  AST_REQ_ONLY_IN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq) else $error("req outside load"); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy) else $error("busy during done"); // R7
  AST_WB_MARKED: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memReq && memWdata[8])) else $error("bad write-back"); // R6
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(selWrEn)) else $error("busy without write"); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr))) else $error("request dropped"); // R4
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(selRdData)) else $error("selector changed while busy"); // R9
  AST_ACC_MARKED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> descAccess[0]) else $error("cached accessed bit clear"); // R5
endmodule

bind segDescCache segDescCache_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/segDescCache_tb.sv
module segDescCache_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] GDT = 32'h0000_1000;
  localparam logic [31:0] LDT = 32'h0008_0000;

  logic clk = 0, rstN = 0, selWrEn = 0, memAck = 0;
  logic [15:0] selWrData = 0, selRdData;
  logic [31:0] gdtBase = GDT, ldtBase = LDT, memAddr, memWdata, memRdata = 0;
  logic memReq, memWe, busy, done, descPresent;
  logic [31:0] descBase;
  logic [19:0] descLimit;
  logic [7:0] descAccess;
  logic [3:0] descFlags;
  logic [1:0] descDpl, rpl;

  segDescCache u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, lat = 0;
  logic [31:0] mem [logic [31:0]];
  typedef struct { logic we; logic [31:0] addr; logic [31:0] wdata; string tag; } op_t;
  op_t expQ[$];
  logic [31:0] eBase; logic [19:0] eLimit; logic [7:0] eAcc; logic [3:0] eFlags;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory responder and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      memAck = 0;
      if (rstN && memReq) begin
        if (lat > 0) repeat (lat) @(negedge clk);
        if (expQ.size() == 0) begin
          chk(0, "R8 unexpected memory op", memAddr, 32'hx);
        end else begin
          op_t e;
          e = expQ.pop_front();
          chk(memWe == e.we, {e.tag, " op kind"}, 32'(memWe), 32'(e.we));
          chk(memAddr == e.addr, {e.tag, " op address"}, memAddr, e.addr);
          if (e.we) chk(memWdata == e.wdata, {e.tag, " write data"}, memWdata, e.wdata);
        end
        memRdata = rd(memAddr);
        if (memWe) mem[memAddr] = memWdata;
        memAck = 1;
      end
    end
  end

  task automatic load(input logic [15:0] sel, input int l, input bit intrude);
    logic [31:0] ent, lo, hi;
    int nOps, cnt;
    lat = l;
    ent = (sel[2] ? LDT : GDT) + {16'h0, sel[15:3], 3'b000};
    lo = rd(ent); hi = rd(ent + 4);
    expQ.push_back('{0, ent, 32'h0, "R3"});
    expQ.push_back('{0, ent + 4, 32'h0, "R4"});
    nOps = 2;
    if (!hi[8]) begin
      expQ.push_back('{1, ent + 4, hi | 32'h100, "R6"});
      nOps = 3;
    end
    eBase = {hi[31:24], hi[7:0], lo[31:16]};
    eLimit = {hi[19:16], lo[15:0]};
    eAcc = hi[15:8] | 8'h01;
    eFlags = hi[23:20];
    @(negedge clk);
    selWrEn = 1; selWrData = sel;
    @(negedge clk);
    selWrEn = 0;
    cnt = 1;
    chk(selRdData == sel, "R2 selector readback", 32'(selRdData), 32'(sel));
    chk(busy == 1, "R2 busy after write", 32'(busy), 1);
    chk(rpl == sel[1:0], "R3 rpl", 32'(rpl), 32'(sel[1:0]));
    if (intrude) begin
      selWrEn = 1; selWrData = ~sel;
      @(negedge clk);
      selWrEn = 0; cnt++;
      chk(selRdData == sel, "R9 write while busy ignored", 32'(selRdData), 32'(sel));
    end
    while (!done && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == nOps * (1 + l) + 1, "R7 done timing", cnt, nOps * (1 + l) + 1);
    chk(busy == 0, "R7 busy low at done", 32'(busy), 0);
    chk(expQ.size() == 0, "R6 all ops issued", expQ.size(), 0);
    chk(descBase == eBase, "R5 base", descBase, eBase);
    chk(descLimit == eLimit, "R5 limit", 32'(descLimit), 32'(eLimit));
    chk(descAccess == eAcc, "R5 access", 32'(descAccess), 32'(eAcc));
    chk(descFlags == eFlags, "R5 flags", 32'(descFlags), 32'(eFlags));
    chk(descPresent == eAcc[7], "R5 present", 32'(descPresent), 32'(eAcc[7]));
    chk(descDpl == eAcc[6:5], "R5 dpl", 32'(descDpl), 32'(eAcc[6:5]));
    @(negedge clk);
    chk(done == 0, "R7 done single pulse", 32'(done), 0);
  endtask

  initial begin
    // descriptors: gdt idx2 (accessed clear), ldt idx5 (accessed set), gdt idx8191
    mem[GDT + 16] = 32'h5678_FFFF; mem[GDT + 20] = 32'h12C_F92_34 >> 0;
    mem[GDT + 20] = 32'h12CF_9234;
    mem[LDT + 40] = 32'hA000_0123; mem[LDT + 44] = 32'h0040_F3BB;
    mem[GDT + 32'hFFF8] = 32'hCAFE_0010; mem[GDT + 32'hFFFC] = 32'hFF80_1A01;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && memReq == 0 && memWe == 0, "R1 reset control", 0, 0);
    chk(selRdData == 0 && descPresent == 0, "R1 reset state", 32'(selRdData), 0);
    rstN = 1;
    load(16'h0010, 0, 0);   // gdt, write-back expected
    load(16'h002F, 1, 0);   // ldt, rpl 3, dpl 3, no write-back
    load(16'hFFF8, 2, 0);   // last gdt index, not present
    load(16'h002F, 0, 0);
    // R8: table edit without reload leaves the cache untouched
    mem[LDT + 44] = 32'h0050_9377;
    repeat (10) @(negedge clk);
    chk(descBase == eBase && descAccess == eAcc, "R8 cache held after table edit", descBase, eBase);
    chk(memReq == 0, "R8 no request while idle", 32'(memReq), 0);
    load(16'h002F, 1, 0);   // reload picks up the edit
    chk(descAccess == 8'h93, "R8 reload sees edit", 32'(descAccess), 32'h93);
    load(16'h0010, 0, 0);   // bit already set in memory now: no write
    load(16'h0010, 2, 1);   // R9 intrusion during load
    chk(selRdData == 16'h0010, "R9 selector after load", 32'(selRdData), 32'h10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule